// File: doc/BRIEF.md
# Q-learning voltage selection controller

This controller chooses, at run time, which of five supply-voltage candidates a logic domain should run at. Each decision starts from two readings. One is a quantized slack bin from an on-chip critical-path monitor. The other is a flag that says whether that slack was zero or negative. A table holds one signed fixed-point score for every pairing of voltage candidate and slack bin. The controller scans the column of the current slack bin and moves to the candidate with the best score. Once it has seen the result of a move, it rewards the power saved and charges a penalty when timing was missed.

The penalty depends on a timing-error probability. The block measures it on its own from a per-cycle error flag over a window whose length software sets. It compares that probability with a programmable bound less a fixed safety margin. Two penalty shapes are available. The abrupt shape jumps from a small constant to a large value at the threshold. The graded shape ramps up linearly toward the threshold, with a programmable slope. The learning rate is a power-of-two fraction chosen by a shift amount. Every score starts at zero after reset.

Top module: `qlearn_vsel`

## Requirements
- R1: `voltIdx` codes the candidates 0..4 as 0.8 V..1.2 V in 0.1 V steps. After reset `voltIdx` is 4 and both `voltValid` and `updateDone` are low.
- R2: Reset clears every score to zero. With all scores equal, the lowest index wins, so the first decision after reset selects index 0.
- R3: A decision is accepted on a clock edge where `sampleValid` is high and the controller is idle. `sampleValid` is ignored while a decision is in progress. `slackBin` values 0..9 mean 0.1..1.0 ns, and any larger value is treated as bin 9.
- R4: The search reads the five scores of the current bin one per clock and picks the highest, with ties going to the lower index. `voltValid` is high for exactly one cycle when the search ends. That is 5 edges after acceptance when no update is pending and 6 edges after when one is. `voltIdx` changes only in that cycle.
- R5: Moving from candidate i to candidate j earns a reward R = trunc(256·(Vi² − Vj²)/(Vmax² − Vmin²)), so 256 stands for 1.0.
- R6: The update is Q ← Q + ((R − P + Qjk − Q) >>> alphaShift), using an arithmetic shift. The result saturates to the signed 16-bit range.
- R7: The update for a decision is applied when the next sample is accepted, to the entry of the old voltage and the old bin. `updateDone` is high for one cycle, one edge after that acceptance. The first sample after reset makes no update.
- R8: The penalty P is zero unless `slackFail` of the sample that follows the move is high.
- R9: `errFlag` is counted every clock. At the end of each window of `windowLen` cycles (0 acts as 1), that count becomes the measured value. The error rate is over threshold when count·4096 ≥ max(tepBound − 41, 0)·windowLen, with `tepBound` in units of 1/4096.
- R10: The large penalty is 8·R when R > 0, and 2 otherwise. In abrupt mode (`gradedMode` = 0) P is 2 below the threshold and the large penalty at or above it.
- R11: In graded mode P is the large penalty at or above the threshold. Below it P = max(2, large − gradeSlope·gap), where gap = floor(max(tepBound − 41, 0)·windowLen/4096) − count, floored at 0.
- R12: After a decision the state becomes (chosen index, bin of the next sample). The next search reads that bin's column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Starts a decision when the controller is idle |
| slackBin | input | 4 | Quantized slack bin of the sample |
| slackFail | input | 1 | Slack of this sample was zero or negative |
| errFlag | input | 1 | Timing error seen this cycle |
| windowLen | input | 16 | Error-measurement window length in cycles |
| tepBound | input | 12 | Error-probability bound, units of 1/4096 |
| gradedMode | input | 1 | 1 selects the graded penalty, 0 the abrupt one |
| gradeSlope | input | 8 | Penalty slope per missing error in graded mode |
| alphaShift | input | 4 | Learning rate 2^-alphaShift |
| voltValid | output | 1 | One-cycle pulse when a new voltage is decided |
| voltIdx | output | 3 | Current voltage candidate index |
| updateDone | output | 1 | One-cycle pulse when a table write completes |

## Verification
The bench goes after the cases where an error would stay hidden at first and only show up in later choices. A wrong tie rule picks a higher voltage when the scores are equal. Updating the new bin's entry instead of the old one steers later searches toward the wrong column. A penalty applied without a failing slack flag teaches the controller to stay at high voltage. The bench also covers a window length of zero, a bound below the margin (always over threshold), slack bins out of range, and samples sent while busy. Any of these, handled wrongly, moves `voltIdx` or the pulse timing away from the reference model.

// File: rtl/qv_pkg.sv
package qv_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic latch;      // capture the incoming sample
    logic update;     // write the pending table entry
    logic scan;       // compare one candidate this cycle
    logic scanFirst;  // first candidate of a search
    logic scanLast;   // final candidate of a search
  } qvStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UPD  = 2'd1,
    ST_SCAN = 2'd2
  } qvState_e;

  // Normalized power-saving reward for a move from candidate i to j,
  // scaled by 2^rf and truncated toward zero.
  function automatic int qvReward(input int i, input int j, input int vMin,
                                  input int vStep, input int nV, input int rf);
    longint vi, vj, vlo, vhi, num, den;
    vi  = longint'(vMin + vStep * i);
    vj  = longint'(vMin + vStep * j);
    vlo = longint'(vMin);
    vhi = longint'(vMin + vStep * (nV - 1));
    num = (vi * vi - vj * vj) * (longint'(1) << rf);
    den = vhi * vhi - vlo * vlo;
    return int'(num / den);
  endfunction

endpackage

// File: rtl/qv_errwin.sv
module qv_errwin #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 12,
  parameter int RHO    = 41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              errFlag,
  input  logic [CNT_W-1:0]  windowLen,
  input  logic [FRAC_W-1:0] tepBound,
  output logic              overBound,
  output logic [CNT_W-1:0]  gapErr
);
  localparam int PW = CNT_W + FRAC_W;
  localparam logic [FRAC_W-1:0] RHO_V = FRAC_W'(RHO);

  logic [CNT_W-1:0]  cycCnt, errCnt, errLast;
  logic [CNT_W-1:0]  effLen;
  logic              winEnd;
  logic [FRAC_W-1:0] eth;
  logic [PW-1:0]     lhs, rhs;
  logic [CNT_W-1:0]  threshErr;

  assign effLen = (windowLen == '0) ? CNT_W'(1) : windowLen;
  assign winEnd = ({1'b0, cycCnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, effLen};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycCnt  <= '0;
      errCnt  <= '0;
      errLast <= '0;
    end else if (winEnd) begin
      errLast <= errCnt + CNT_W'(errFlag);
      cycCnt  <= '0;
      errCnt  <= '0;
    end else begin
      cycCnt  <= cycCnt + CNT_W'(1);
      errCnt  <= errCnt + CNT_W'(errFlag);
    end
  end

  // Rate comparison by cross-multiplication, no divider.
  assign eth       = (tepBound > RHO_V) ? (tepBound - RHO_V) : '0;
  assign lhs       = {errLast, {FRAC_W{1'b0}}};
  assign rhs       = PW'(eth) * PW'(effLen);
  assign overBound = (lhs >= rhs);
  assign threshErr = rhs[PW-1:FRAC_W];
  assign gapErr    = (threshErr > errLast) ? (threshErr - errLast) : '0;

endmodule

// File: rtl/qv_penalty.sv
module qv_penalty #(
  parameter int QW      = 16,
  parameter int CNT_W   = 16,
  parameter int GAMMA_W = 8,
  parameter int SIGMA   = 8,
  parameter int EPS     = 2
) (
  input  logic signed [QW-1:0] reward,
  input  logic                 slackFail,
  input  logic                 overBound,
  input  logic                 gradedMode,
  input  logic [GAMMA_W-1:0]   gradeSlope,
  input  logic [CNT_W-1:0]     gapErr,
  output logic signed [31:0]   penalty
);
  localparam logic signed [31:0] EPS_V   = 32'(EPS);
  localparam logic signed [31:0] SIGMA_V = 32'(SIGMA);

  logic signed [31:0] rwdX, highPen, linPen;
  logic [31:0]        cutU;

  assign rwdX    = {{(32-QW){reward[QW-1]}}, reward};
  assign highPen = (rwdX > 0) ? (SIGMA_V * rwdX) : EPS_V;
  assign cutU    = 32'(gradeSlope) * 32'(gapErr);
  assign linPen  = highPen - $signed(cutU);

  always_comb begin
    if (!slackFail)      penalty = '0;
    else if (overBound)  penalty = highPen;
    else if (!gradedMode) penalty = EPS_V;
    else if (linPen > EPS_V) penalty = linPen;
    else                 penalty = EPS_V;
  end

endmodule

// File: rtl/qv_ctrl.sv
module qv_ctrl
  import qv_pkg::*;
#(
  parameter int NUM_V = 5,
  localparam int VW   = $clog2(NUM_V)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sampleValid,
  output qvStrobe_t     strobe,
  output logic [VW-1:0] scanIdx,
  output logic          voltValid,
  output logic          updateDone
);
  qvState_e      state;
  logic [VW-1:0] scanCnt;
  logic          havePrev;

  assign strobe.latch     = (state == ST_IDLE) && sampleValid;
  assign strobe.update    = (state == ST_UPD);
  assign strobe.scan      = (state == ST_SCAN);
  assign strobe.scanFirst = strobe.scan && (scanCnt == '0);
  assign strobe.scanLast  = strobe.scan && (scanCnt == VW'(NUM_V - 1));
  assign scanIdx          = scanCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      scanCnt    <= '0;
      havePrev   <= 1'b0;
      voltValid  <= 1'b0;
      updateDone <= 1'b0;
    end else begin
      voltValid  <= strobe.scanLast;
      updateDone <= strobe.update;
      unique case (state)
        ST_IDLE: begin
          scanCnt <= '0;
          if (sampleValid) state <= havePrev ? ST_UPD : ST_SCAN;
        end
        ST_UPD: state <= ST_SCAN;
        ST_SCAN: begin
          if (strobe.scanLast) begin
            state    <= ST_IDLE;
            scanCnt  <= '0;
            havePrev <= 1'b1;
          end else begin
            scanCnt <= scanCnt + VW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/qv_datapath.sv
module qv_datapath
  import qv_pkg::*;
#(
  parameter int NUM_V     = 5,
  parameter int NUM_BINS  = 10,
  parameter int QW        = 16,
  parameter int CNT_W     = 16,
  parameter int FRAC_W    = 12,
  parameter int RHO       = 41,
  parameter int GAMMA_W   = 8,
  parameter int SHIFT_W   = 4,
  parameter int RF        = 8,
  parameter int SIGMA     = 8,
  parameter int EPS       = 2,
  parameter int V_MIN_MV  = 800,
  parameter int V_STEP_MV = 100,
  localparam int VW       = $clog2(NUM_V),
  localparam int BW       = $clog2(NUM_BINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  qvStrobe_t          strobe,
  input  logic [VW-1:0]      scanIdx,
  input  logic [BW-1:0]      slackBin,
  input  logic               slackFail,
  input  logic               errFlag,
  input  logic [CNT_W-1:0]   windowLen,
  input  logic [FRAC_W-1:0]  tepBound,
  input  logic               gradedMode,
  input  logic [GAMMA_W-1:0] gradeSlope,
  input  logic [SHIFT_W-1:0] alphaShift,
  output logic [VW-1:0]      voltIdx
);
  localparam logic signed [31:0] QMAX = 32'(2 ** (QW - 1) - 1);
  localparam logic signed [31:0] QMIN = -32'(2 ** (QW - 1));

  logic signed [QW-1:0] qTab      [NUM_V][NUM_BINS];
  logic signed [QW-1:0] rewardTab [NUM_V][NUM_V];

  logic [VW-1:0] curV, iPrev, jPrev, bestIdx, candBest;
  logic [BW-1:0] kCur, kPrev, binClamp;
  logic          failCur;
  logic signed [QW-1:0] bestQ, candQ, qIk, qJk, rwd, newQ;
  logic          takeIt, overBound;
  logic [CNT_W-1:0] gapErr;
  logic signed [31:0] penalty, target, diff, stepQ, sumQ;

  // Reward constants, computed at elaboration.
  for (genvar gi = 0; gi < NUM_V; gi++) begin : g_rwdRow
    for (genvar gj = 0; gj < NUM_V; gj++) begin : g_rwdCol
      assign rewardTab[gi][gj] = QW'(qvReward(gi, gj, V_MIN_MV, V_STEP_MV, NUM_V, RF));
    end
  end

  assign binClamp = (int'(slackBin) >= NUM_BINS) ? BW'(NUM_BINS - 1) : slackBin;

  qv_errwin #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .RHO(RHO)) u_errwin (
    .clk      (clk),
    .rst_n    (rst_n),
    .errFlag  (errFlag),
    .windowLen(windowLen),
    .tepBound (tepBound),
    .overBound(overBound),
    .gapErr   (gapErr)
  );

  assign qIk = qTab[iPrev][kPrev];
  assign qJk = qTab[jPrev][kPrev];
  assign rwd = rewardTab[iPrev][jPrev];

  qv_penalty #(.QW(QW), .CNT_W(CNT_W), .GAMMA_W(GAMMA_W), .SIGMA(SIGMA), .EPS(EPS)) u_pen (
    .reward    (rwd),
    .slackFail (failCur),
    .overBound (overBound),
    .gradedMode(gradedMode),
    .gradeSlope(gradeSlope),
    .gapErr    (gapErr),
    .penalty   (penalty)
  );

  // Q <- Q + alpha*(R - P + Qjk - Q), alpha = 2^-alphaShift
  assign target = 32'(rwd) - penalty + 32'(qJk);
  assign diff   = target - 32'(qIk);
  assign stepQ  = diff >>> alphaShift;
  assign sumQ   = 32'(qIk) + stepQ;

  always_comb begin
    if (sumQ > QMAX)      newQ = QMAX[QW-1:0];
    else if (sumQ < QMIN) newQ = QMIN[QW-1:0];
    else                  newQ = sumQ[QW-1:0];
  end

  // Sequential maximum search over the current bin's column.
  assign candQ    = qTab[scanIdx][kCur];
  assign takeIt   = strobe.scanFirst || (candQ > bestQ);
  assign candBest = takeIt ? scanIdx : bestIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_V; v++)
        for (int b = 0; b < NUM_BINS; b++)
          qTab[v][b] <= '0;
    end else if (strobe.update) begin
      qTab[iPrev][kPrev] <= newQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curV    <= VW'(NUM_V - 1);
      iPrev   <= '0;
      jPrev   <= '0;
      kPrev   <= '0;
      kCur    <= '0;
      failCur <= 1'b0;
      bestIdx <= '0;
      bestQ   <= '0;
    end else begin
      if (strobe.latch) begin
        kCur    <= binClamp;
        failCur <= slackFail;
      end
      if (strobe.scan) begin
        bestIdx <= candBest;
        bestQ   <= takeIt ? candQ : bestQ;
      end
      if (strobe.scanLast) begin
        curV  <= candBest;
        iPrev <= curV;
        jPrev <= candBest;
        kPrev <= kCur;
      end
    end
  end

  assign voltIdx = curV;

endmodule

// File: rtl/qlearn_vsel.sv
module qlearn_vsel
  import qv_pkg::*;
#(
  parameter int NUM_V     = 5,
  parameter int NUM_BINS  = 10,
  parameter int QW        = 16,
  parameter int CNT_W     = 16,
  parameter int FRAC_W    = 12,
  parameter int RHO       = 41,
  parameter int GAMMA_W   = 8,
  parameter int SHIFT_W   = 4,
  parameter int RF        = 8,
  parameter int SIGMA     = 8,
  parameter int EPS       = 2,
  parameter int V_MIN_MV  = 800,
  parameter int V_STEP_MV = 100,
  localparam int VIDX_W   = $clog2(NUM_V),
  localparam int BIN_W    = $clog2(NUM_BINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sampleValid,
  input  logic [BIN_W-1:0]   slackBin,
  input  logic               slackFail,
  input  logic               errFlag,
  input  logic [CNT_W-1:0]   windowLen,
  input  logic [FRAC_W-1:0]  tepBound,
  input  logic               gradedMode,
  input  logic [GAMMA_W-1:0] gradeSlope,
  input  logic [SHIFT_W-1:0] alphaShift,
  output logic               voltValid,
  output logic [VIDX_W-1:0]  voltIdx,
  output logic               updateDone
);
  qvStrobe_t         ctlStrobe;
  logic [VIDX_W-1:0] scanIdx;
  logic              updPulse, latchPulse;

  qv_ctrl #(.NUM_V(NUM_V)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleValid(sampleValid),
    .strobe     (ctlStrobe),
    .scanIdx    (scanIdx),
    .voltValid  (voltValid),
    .updateDone (updateDone)
  );

  qv_datapath #(
    .NUM_V(NUM_V), .NUM_BINS(NUM_BINS), .QW(QW), .CNT_W(CNT_W),
    .FRAC_W(FRAC_W), .RHO(RHO), .GAMMA_W(GAMMA_W), .SHIFT_W(SHIFT_W),
    .RF(RF), .SIGMA(SIGMA), .EPS(EPS), .V_MIN_MV(V_MIN_MV), .V_STEP_MV(V_STEP_MV)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (ctlStrobe),
    .scanIdx   (scanIdx),
    .slackBin  (slackBin),
    .slackFail (slackFail),
    .errFlag   (errFlag),
    .windowLen (windowLen),
    .tepBound  (tepBound),
    .gradedMode(gradedMode),
    .gradeSlope(gradeSlope),
    .alphaShift(alphaShift),
    .voltIdx   (voltIdx)
  );

  assign updPulse   = ctlStrobe.update;
  assign latchPulse = ctlStrobe.latch;

endmodule

// File: rtl/qlearn_vsel_chk.sv
module qlearn_vsel_chk #(
  parameter int NUM_V = 5,
  parameter int VW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          voltValid,
  input logic [VW-1:0] voltIdx,
  input logic          updateDone,
  input logic          updPulse,
  input logic          latchPulse
);
  // R1: index always names an existing candidate
  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(voltIdx) < NUM_V);

  // R4: the index moves only in the decision cycle
  p_idx_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (voltIdx != $past(voltIdx)) |-> voltValid);

  // R4: decision pulse lasts one cycle
  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    voltValid |=> !voltValid);

  // R7: a table write is reported on the following cycle
  p_update_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    updPulse |=> updateDone);

  // R7: write report and decision never coincide
  p_done_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    updateDone |-> !voltValid);

  // R3: an accepted sample is never answered on the next cycle
  p_latch_no_instant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    latchPulse |=> !voltValid);

endmodule

bind qlearn_vsel qlearn_vsel_chk #(.NUM_V(NUM_V), .VW(VIDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .voltValid (voltValid),
  .voltIdx   (voltIdx),
  .updateDone(updateDone),
  .updPulse  (updPulse),
  .latchPulse(latchPulse)
);

// File: tb/sim_qlearn_vsel.sv
module sim_qlearn_vsel;
  localparam int NV = 5, NB = 10, EPS = 2, SIGMA = 8, RHO = 41;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        sampleValid = 1'b0, slackFail = 1'b0, errFlag = 1'b0, gradedMode = 1'b0;
  logic [3:0]  slackBin = '0, alphaShift = '0;
  logic [15:0] windowLen = 16'd16;
  logic [11:0] tepBound = 12'd400;
  logic [7:0]  gradeSlope = '0;
  logic        voltValid, updateDone;
  logic [2:0]  voltIdx;

  qlearn_vsel u0 (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .slackBin(slackBin),
    .slackFail(slackFail), .errFlag(errFlag), .windowLen(windowLen),
    .tepBound(tepBound), .gradedMode(gradedMode), .gradeSlope(gradeSlope),
    .alphaShift(alphaShift), .voltValid(voltValid), .voltIdx(voltIdx),
    .updateDone(updateDone)
  );

  int checks = 0, errors = 0, vvCount = 0, errDensity = 0;
  bit finished = 0;
  logic [15:0] lfsrE = 16'hACE1, lfsrS = 16'h1D2B;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int qm [NV][NB];
  int cyc = 0, busyUntil = 0, voltEdge = -1, updEdge = -1, pendEdge = -1;
  int curVm = NV - 1, visV = NV - 1, expBest = 0, iP = 0, jP = 0, kP = 0, kC = 0;
  bit havePrevM = 0, failC = 0;
  int winCnt = 0, errCntM = 0, errLastM = 0;

  function automatic int rewardM(input int i, input int j);
    longint vi = 800 + 100 * i, vj = 800 + 100 * j;
    return int'(((vi * vi - vj * vj) * 256) / (1200 * 1200 - 800 * 800));
  endfunction

  function automatic int penM(input int r);
    int w = (windowLen == 0) ? 1 : int'(windowLen);
    int eth = (int'(tepBound) > RHO) ? int'(tepBound) - RHO : 0;
    int prod = eth * w;
    bit over = (errLastM * 4096) >= prod;
    int gap = (prod / 4096 > errLastM) ? prod / 4096 - errLastM : 0;
    int high = (r > 0) ? SIGMA * r : EPS;
    int lin = high - int'(gradeSlope) * gap;
    if (!failC) return 0;
    if (over) return high;
    if (!gradedMode) return EPS;
    return (lin > EPS) ? lin : EPS;
  endfunction

  task automatic modelUpdate();
    int r = rewardM(iP, jP);
    int d = r - penM(r) + qm[jP][kP] - qm[iP][kP];
    int nq = qm[iP][kP] + (d >>> alphaShift);
    if (nq > 32767) nq = 32767;
    if (nq < -32768) nq = -32768;
    qm[iP][kP] = nq;
  endtask

  task automatic modelDecide();
    int best = 0;
    for (int c = 1; c < NV; c++) if (qm[c][kC] > qm[best][kC]) best = c;
    iP = curVm; jP = best; kP = kC; curVm = best; expBest = best; havePrevM = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < NV; v++) for (int b = 0; b < NB; b++) qm[v][b] = 0;
      cyc = 0; busyUntil = 0; voltEdge = -1; updEdge = -1; pendEdge = -1;
      curVm = NV - 1; visV = NV - 1; havePrevM = 0;
      winCnt = 0; errCntM = 0; errLastM = 0;
    end else begin
      int w;
      cyc++;
      if (cyc == pendEdge) begin
        modelUpdate();
        modelDecide();
        voltEdge = cyc + NV;
      end
      if (cyc == voltEdge) visV = expBest;
      if (sampleValid && cyc > busyUntil) begin
        kC = (int'(slackBin) >= NB) ? NB - 1 : int'(slackBin);
        failC = slackFail;
        if (havePrevM) begin
          pendEdge = cyc + 1; updEdge = cyc + 1; busyUntil = cyc + 1 + NV;
        end else begin
          modelDecide();
          voltEdge = cyc + NV; busyUntil = voltEdge;
        end
      end
      w = (windowLen == 0) ? 1 : int'(windowLen);
      if (winCnt + 1 >= w) begin
        errLastM = errCntM + int'(errFlag); winCnt = 0; errCntM = 0;
      end else begin
        winCnt++; errCntM += int'(errFlag);
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (voltValid) vvCount++;
      chk(voltValid == (cyc == voltEdge), "R4 voltValid timing", int'(voltValid), int'(cyc == voltEdge));
      chk(updateDone == (cyc == updEdge), "R7 updateDone timing", int'(updateDone), int'(cyc == updEdge));
      chk(int'(voltIdx) == visV, "R4 R5 R6 R8 R9 R10 R11 R12 voltIdx", int'(voltIdx), visV);
    end
  end

  // Per-cycle timing-error stimulus.
  always @(negedge clk) begin
    lfsrE = {lfsrE[14:0], lfsrE[15] ^ lfsrE[13] ^ lfsrE[12] ^ lfsrE[10]};
    errFlag = (int'(lfsrE[7:0]) < errDensity);
  end

  task automatic stepS();
    lfsrS = {lfsrS[14:0], lfsrS[15] ^ lfsrS[13] ^ lfsrS[12] ^ lfsrS[10]};
  endtask

  task automatic sendSample(input int bin, input bit fail, input bit poke);
    @(negedge clk);
    sampleValid = 1'b1; slackBin = 4'(bin); slackFail = fail;
    @(negedge clk);
    sampleValid = 1'b0;
    if (poke) begin  // R3: arrives while busy, must be ignored
      @(negedge clk);
      sampleValid = 1'b1; slackBin = 4'((bin + 5) % 16); slackFail = ~fail;
      @(negedge clk);
      sampleValid = 1'b0;
    end
    while (!voltValid) @(negedge clk);
  endtask

  task automatic runPhase(input bit graded, input int aSh, input int gam, input int bound,
                          input int wl, input int dens, input int failPct, input int n);
    int startCount;
    @(negedge clk);
    gradedMode = graded; alphaShift = 4'(aSh); gradeSlope = 8'(gam);
    tepBound = 12'(bound); windowLen = 16'(wl); errDensity = dens;
    #1 startCount = vvCount;
    for (int s = 0; s < n; s++) begin
      stepS();
      sendSample(int'(lfsrS[3:0]), (int'(lfsrS[11:4]) % 100) < failPct, (s % 7) == 3);
    end
    @(negedge clk);
    #1 chk(vvCount - startCount == n, "R3 one decision per accepted sample", vvCount - startCount, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(voltIdx == 3'd4, "R1 reset voltIdx", int'(voltIdx), 4);
    chk(voltValid == 1'b0, "R1 reset voltValid", int'(voltValid), 0);
    chk(updateDone == 1'b0, "R1 reset updateDone", int'(updateDone), 0);
    rst_n = 1'b1;
    // R2: all-zero table, ties to lowest index
    sendSample(3, 1'b0, 1'b0);
    chk(voltIdx == 3'd0, "R2 first decision", int'(voltIdx), 0);
    // R5 R6 R7: Q[4][3] becomes 256, search on bin 3 picks index 4
    sendSample(3, 1'b0, 1'b0);
    chk(voltIdx == 3'd4, "R4 R5 R6 highest score wins", int'(voltIdx), 4);
    runPhase(1'b0, 0, 0, 400, 16, 0, 40, 20);    // R8: failures below threshold
    runPhase(1'b0, 1, 0, 400, 20, 40, 50, 60);   // R10 abrupt
    runPhase(1'b1, 2, 20, 500, 32, 60, 50, 60);  // R11 graded
    runPhase(1'b1, 0, 200, 1000, 0, 128, 60, 50);// R9 window of zero
    runPhase(1'b0, 0, 0, 0, 64, 10, 70, 60);     // R9 bound below margin
    runPhase(1'b1, 3, 5, 4095, 8, 200, 30, 50);  // R11 high bound, dense errors
    runPhase(1'b1, 0, 1, 2000, 100, 90, 80, 60); // R12 bin hopping, R3 clamp
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule